// File: doc/BRIEF.md
# Startup and Clock-Sync Output Guard

This block decides when converted audio samples may reach the serial output of an audio converter. After the supply-good indication rises, it keeps the converter's logic in reset for a fixed number of master clocks. It then holds the output muted for a long settling interval that is counted in sample periods, meaning word-clock rising edges. The datapath drives the bipolar-zero word 16'h0000 whenever the mute flag is high.

Once running, the block measures every word-clock period in master clocks and compares it with the nominal period. Deviations are judged in bit-clock units, and the `bclk_ratio` input gives the number of master clocks per bit clock. A large deviation, or a word clock that stops, declares loss of sync and mutes the output. Only a run of clean periods lifts the mute again. A middle band of deviations neither sets nor clears loss of sync, which keeps a jittery clock from toggling the mute.

Top module: `startup_sync_guard`

## Requirements
- R1: `core_rst` is 1 while `rst` is 1 or `pwr_good` is 0. It falls after `pwr_good` has been sampled high on RST_CLKS consecutive clock edges. A `pwr_good` of 0 sampled at any later edge sets `core_rst` to 1 from that edge on.
- R2: While `core_rst` is 1, and during `rst`, `mute` is 1 and `data_valid` is 0. The datapath then outputs the bipolar-zero word 16'h0000.
- R3: After `core_rst` falls, `mute` stays 1 until SETTLE_SAMPLES word-clock rising edges have been seen. It falls within two clocks of the edge that completes the count, provided sync is not lost.
- R4: A measured word period whose distance from EXPECT_MCLK master clocks exceeds 6 bit clocks (6 × `bclk_ratio` master clocks) declares loss of sync. `mute` is 1 within two clocks of the edge that closes that period.
- R5: If more than EXPECT_MCLK + 6 × `bclk_ratio` master clocks pass after a word-clock rising edge without another rising edge, loss of sync is declared without waiting for the edge.
- R6: A period whose distance is below 5 bit clocks causes no muting while in sync.
- R7: A distance of 5 or 6 bit clocks leaves the sync state unchanged, both in sync and out of sync. Out of sync, such a period breaks the run of clean periods.
- R8: Out of sync, two consecutive periods below 5 bit clocks restore sync at the next rising edge, unless the period that edge closes exceeds 6 bit clocks. `mute` then falls within two clocks.
- R9: The first word-clock rising edge after `core_rst` falls only starts the measurement. Neither the interval before that edge nor any timeout before it counts against sync.
- R10: `data_valid` is always the complement of `mute`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good | input | 1 | Supply-good indication, synchronous to `clk` |
| wclk | input | 1 | Word clock, already synchronised to `clk` |
| bclk_ratio | input | RATIO_W | Master clocks per bit clock |
| core_rst | output | 1 | Reset for the converter logic, registered |
| mute | output | 1 | High while the output must carry 16'h0000 |
| data_valid | output | 1 | High while converted samples may pass |

## Verification
The assertions assume three things about the inputs. `wclk` and `pwr_good` are clean single-clock-domain signals with no metastability, and `bclk_ratio` holds still during any word period that is being measured. The stimulus meets these assumptions. It changes every input only on the falling clock edge, and it alters `bclk_ratio` only after a period has been judged and the guard is back in sync. The drift sweeps build each word period from a whole number of master clocks, so every measured period is exactly the length the bench intended.

// File: rtl/guard_pkg.sv
package guard_pkg;
  // Outcome of judging one measured word period
  typedef enum logic [1:0] {
    PER_CLEAN = 2'd0,
    PER_BAND  = 2'd1,
    PER_BAD   = 2'd2
  } period_class_t;

  localparam int TRIG_BITS = 6;  // deviation above this many bit clocks is loss of sync
  localparam int OK_BITS   = 5;  // deviation below this many bit clocks is clean
  localparam int RUN_NEED  = 2;  // clean periods needed before release
endpackage

// File: rtl/guard_por_timer.sv
module guard_por_timer #(
  parameter int RST_CLKS = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_good,
  output logic core_rst
);
  localparam int CW = $clog2(RST_CLKS + 1);
  localparam logic [CW-1:0] LAST = CW'(RST_CLKS);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !pwr_good) begin
      cnt      <= '0;
      core_rst <= 1'b1;
    end else if (core_rst) begin
      cnt      <= cnt + CW'(1);
      core_rst <= (cnt + CW'(1)) != LAST;
    end
  end

  // R1: losing power puts the core back into reset on the next edge
  p_drop_resets_r1: assert property (@(posedge clk) disable iff (rst)
    !pwr_good |=> core_rst);

  // R1: release only happens with power present
  p_release_needs_power_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(core_rst) |-> $past(pwr_good));
endmodule

// File: rtl/guard_settle_timer.sv
module guard_settle_timer #(
  parameter int SETTLE_SAMPLES = 18436
) (
  input  logic clk,
  input  logic core_rst,
  input  logic word_rise,
  output logic settled
);
  localparam int CW = $clog2(SETTLE_SAMPLES + 1);
  localparam logic [CW-1:0] LAST = CW'(SETTLE_SAMPLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (core_rst) begin
      cnt     <= '0;
      settled <= 1'b0;
    end else if (word_rise && !settled) begin
      cnt     <= cnt + CW'(1);
      settled <= (cnt + CW'(1)) == LAST;
    end
  end

  // R3: once settled, the interval never restarts without a reset
  p_settle_sticky_r3: assert property (@(posedge clk) disable iff (core_rst)
    settled |=> settled);
endmodule

// File: rtl/guard_drift_monitor.sv
module guard_drift_monitor
  import guard_pkg::*;
#(
  parameter int EXPECT_MCLK = 256,
  parameter int RATIO_W     = 4
) (
  input  logic               clk,
  input  logic               core_rst,
  input  logic               wclk,
  input  logic [RATIO_W-1:0] bclk_ratio,
  output logic               word_rise,
  output logic               sync_lost
);
  localparam int LIM_MAX = TRIG_BITS * ((1 << RATIO_W) - 1);
  localparam int PMAX    = EXPECT_MCLK + LIM_MAX + 2;
  localparam int PW      = $clog2(PMAX + 1) + 1;
  localparam logic [PW-1:0] EXP_W  = PW'(EXPECT_MCLK);
  localparam logic [PW-1:0] PMAX_W = PW'(PMAX);

  logic          prev_w;
  logic          armed;
  logic [PW-1:0] per_cnt;
  logic [1:0]    good_run;

  logic [PW-1:0] diff, trig_lim, ok_lim;
  logic          timeout;
  period_class_t cls;

  assign word_rise = wclk & ~prev_w;

  always_comb begin
    diff     = (per_cnt >= EXP_W) ? (per_cnt - EXP_W) : (EXP_W - per_cnt);
    trig_lim = PW'(TRIG_BITS) * PW'(bclk_ratio);
    ok_lim   = PW'(OK_BITS) * PW'(bclk_ratio);
    if (diff > trig_lim)    cls = PER_BAD;
    else if (diff < ok_lim) cls = PER_CLEAN;
    else                    cls = PER_BAND;
    timeout = armed && !word_rise && (per_cnt > (EXP_W + trig_lim));
  end

  always_ff @(posedge clk) begin
    if (core_rst) begin
      prev_w    <= wclk;
      armed     <= 1'b0;
      per_cnt   <= '0;
      sync_lost <= 1'b0;
      good_run  <= '0;
    end else begin
      prev_w <= wclk;
      if (word_rise) begin
        per_cnt <= PW'(1);
        armed   <= 1'b1;
      end else if (per_cnt != PMAX_W) begin
        per_cnt <= per_cnt + PW'(1);
      end

      if (timeout) begin
        sync_lost <= 1'b1;
        good_run  <= '0;
      end else if (word_rise && armed) begin
        if (cls == PER_BAD) begin
          sync_lost <= 1'b1;
          good_run  <= '0;
        end else if (sync_lost) begin
          if (good_run == 2'(RUN_NEED)) begin
            sync_lost <= 1'b0;
            good_run  <= '0;
          end else if (cls == PER_CLEAN) begin
            good_run <= good_run + 2'd1;
          end else begin
            good_run <= '0;
          end
        end
      end
    end
  end

  // R8: sync only returns after the full run of clean periods
  p_release_after_run_r8: assert property (@(posedge clk) disable iff (core_rst)
    $fell(sync_lost) |-> ($past(good_run) == 2'(RUN_NEED)));

  // R7: the run counter stays in range and is idle while in sync
  p_run_idle_in_sync_r7: assert property (@(posedge clk) disable iff (core_rst)
    !sync_lost |-> (good_run == 2'd0));

  // R9: no loss of sync can be declared before the first edge arms the monitor
  p_unarmed_quiet_r9: assert property (@(posedge clk) disable iff (core_rst)
    !armed |=> !sync_lost);
endmodule

// File: rtl/startup_sync_guard.sv
module startup_sync_guard #(
  parameter int RST_CLKS       = 1024,
  parameter int SETTLE_SAMPLES = 18436,
  parameter int EXPECT_MCLK    = 256,
  parameter int RATIO_W        = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pwr_good,
  input  logic               wclk,
  input  logic [RATIO_W-1:0] bclk_ratio,
  output logic               core_rst,
  output logic               mute,
  output logic               data_valid
);
  logic word_rise;
  logic settled;
  logic sync_lost;
  logic hold_off;

  guard_por_timer #(.RST_CLKS(RST_CLKS)) u_por (
    .clk      (clk),
    .rst      (rst),
    .pwr_good (pwr_good),
    .core_rst (core_rst)
  );

  guard_drift_monitor #(.EXPECT_MCLK(EXPECT_MCLK), .RATIO_W(RATIO_W)) u_drift (
    .clk        (clk),
    .core_rst   (core_rst),
    .wclk       (wclk),
    .bclk_ratio (bclk_ratio),
    .word_rise  (word_rise),
    .sync_lost  (sync_lost)
  );

  guard_settle_timer #(.SETTLE_SAMPLES(SETTLE_SAMPLES)) u_settle (
    .clk       (clk),
    .core_rst  (core_rst),
    .word_rise (word_rise),
    .settled   (settled)
  );

  assign hold_off = core_rst | ~settled | sync_lost;

  always_ff @(posedge clk) begin
    if (rst) begin
      mute       <= 1'b1;
      data_valid <= 1'b0;
    end else begin
      mute       <= hold_off;
      data_valid <= ~hold_off;
    end
  end

  // R2: the core in reset means muted output one clock later
  p_reset_mutes_r2: assert property (@(posedge clk) disable iff (rst)
    core_rst |=> mute);

  // R4: lost sync reaches the mute flag on the next clock
  p_lost_mutes_r4: assert property (@(posedge clk) disable iff (rst)
    sync_lost |=> (mute && !data_valid));

  // R3: valid data never appears before settling completes
  p_valid_after_settle_r3: assert property (@(posedge clk) disable iff (rst)
    data_valid |-> $past(settled));

  // R10: the two flags never agree
  p_flags_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
    mute != data_valid);
endmodule

// File: tb/sim_startup_sync_guard.sv
module sim_startup_sync_guard;
  localparam int RST_CLKS = 8;
  localparam int SETTLE   = 3;
  localparam int EXPECT   = 32;
  localparam int RW       = 4;

  logic clk = 1'b0;
  logic rst, pwr_good, wclk;
  logic [RW-1:0] ratio;
  logic core_rst, mute, data_valid;
  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  startup_sync_guard #(
    .RST_CLKS(RST_CLKS), .SETTLE_SAMPLES(SETTLE),
    .EXPECT_MCLK(EXPECT), .RATIO_W(RW)
  ) u0 (
    .clk(clk), .rst(rst), .pwr_good(pwr_good), .wclk(wclk),
    .bclk_ratio(ratio), .core_rst(core_rst), .mute(mute),
    .data_valid(data_valid)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic expect_mute(input string req, input logic exp);
    chk(req, mute, exp);
    chk("R10", data_valid, ~exp);
  endtask

  // one word period of p master clocks, rising edge seen at its first clock
  task automatic word(input int p);
    for (int i = 0; i < p; i++) begin
      @(negedge clk);
      wclk = (i < p / 2);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wclk = 1'b0;
    end
  endtask

  // after the word whose edge judged a bad period: two clean runs then release
  task automatic recover(input string req);
    word(EXPECT);
    expect_mute(req, 1'b1);
    word(EXPECT);
    expect_mute(req, 1'b1);
    word(EXPECT);
    expect_mute(req, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; pwr_good = 1'b0; wclk = 1'b0; ratio = 4'd2;
    repeat (4) @(negedge clk);
    chk("R1", core_rst, 1'b1);
    expect_mute("R2", 1'b1);

    rst = 1'b0;
    repeat (20) @(negedge clk);
    chk("R1", core_rst, 1'b1);
    expect_mute("R2", 1'b1);

    pwr_good = 1'b1;
    repeat (RST_CLKS - 1) @(negedge clk);
    chk("R1", core_rst, 1'b1);
    @(negedge clk);
    chk("R1", core_rst, 1'b0);
    @(negedge clk);
    expect_mute("R3", 1'b1);

    // long quiet gap before the first edge must not count (R9)
    idle(100);
    expect_mute("R3", 1'b1);
    word(EXPECT);
    expect_mute("R3", 1'b1);
    word(EXPECT);
    expect_mute("R3", 1'b1);
    word(EXPECT);
    expect_mute("R9", 1'b0);

    // near-exhaustive sweep of period deviation for three bit-clock ratios
    for (int r = 1; r <= 3; r++) begin
      ratio = 4'(r);
      for (int d = -(6 * r + 2); d <= 6 * r + 2; d++) begin
        int ad;
        logic bad;
        ad  = (d < 0) ? -d : d;
        bad = (ad > 6 * r);
        word(EXPECT + d);
        word(EXPECT);
        if (bad) expect_mute("R4", 1'b1);
        else if (ad < 5 * r) expect_mute("R6", 1'b0);
        else expect_mute("R7", 1'b0);
        if (bad) recover("R8");
      end
    end

    // stopped word clock (R5)
    ratio = 4'd2;
    word(EXPECT);
    idle(80);
    expect_mute("R5", 1'b1);
    word(EXPECT);
    expect_mute("R5", 1'b1);
    recover("R8");

    // band period while out of sync breaks the clean run (R7)
    word(EXPECT + 13);
    word(EXPECT);
    expect_mute("R4", 1'b1);
    word(EXPECT + 11);
    expect_mute("R7", 1'b1);
    word(EXPECT);
    expect_mute("R7", 1'b1);
    word(EXPECT);
    expect_mute("R7", 1'b1);
    word(EXPECT);
    expect_mute("R7", 1'b1);
    word(EXPECT);
    expect_mute("R8", 1'b0);

    // power loss and second start-up
    pwr_good = 1'b0;
    @(negedge clk);
    chk("R1", core_rst, 1'b1);
    @(negedge clk);
    expect_mute("R2", 1'b1);
    pwr_good = 1'b1;
    repeat (RST_CLKS) @(negedge clk);
    chk("R1", core_rst, 1'b0);
    word(EXPECT);
    word(EXPECT);
    expect_mute("R3", 1'b1);
    word(EXPECT);
    expect_mute("R3", 1'b0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule